// File: doc/BRIEF.md
# Two-way write-back data cache

This block is a compact set-associative data cache placed between a 32-bit core request port and a memory bus that moves one word per transfer. It holds 32 sets of two ways, each line eight words wide, and keeps modified data locally until a line has to make room for another one. Every line that is brought in is allocated, whether the access that missed was a load, a store or a prefetch.

The core presents one operation at a time: a load, which returns a word; a store, which writes a word under a byte enable; or a prefetch, which only makes sure the addressed line is resident. On a miss the port is held busy. The controller chooses a victim way from a per-set recency bit, writes the victim out first if it carries modified data, refills the line from memory and then completes the access as a hit. Each word moved on the memory side is a request held until a one-cycle acknowledge.

Top module: `dcache_2way`

## Requirements
- R1: Address bits [4:2] select the word in a line, bits [9:5] select one of 32 sets and bits [31:10] form the tag. The low two address bits are ignored, and every memory beat address ends in 2'b00.
- R2: After reset no line is valid, so the first access to any address misses. A lookup hits only when the way's valid bit is set and its stored tag equals the address tag.
- R3: Each set has one recency bit, cleared by reset. Any access that ends on way 0 (load, store or prefetch, hit or after a fill) sets it to 1. Any access that ends on way 1 clears it to 0.
- R4: On a miss the victim is way 1 when the set's recency bit is 1, and way 0 when it is 0.
- R5: A victim that is valid and dirty is written out as eight write beats before any refill beat. The beats are in ascending word order from the old line base, which is {old tag, set, 5'b0}, and the address rises by 4 per beat. A clean victim produces no write beat.
- R6: A refill is eight read beats in ascending word order from {new tag, set, 5'b0}. Each beat's read data goes into the victim way. The new tag is then installed and the line is marked valid and clean.
- R7: A store replaces byte i of the addressed word, bits [8i+7:8i], only where req_be[i] is 1. The other bytes keep their old value, and the line becomes dirty.
- R8: A store that misses first allocates the line (write-back if needed, then refill). It then merges the data and marks the line dirty, so a later eviction of that line writes the merged word.
- R9: Opcodes: 2'b00 is a load, 2'b01 is a store, 2'b10 is a prefetch. A prefetch does the same lookup, recency update and miss handling as a load. It returns zero data and never sets a dirty bit.
- R10: A memory beat raises mem_req with mem_addr, mem_we and mem_wdata and holds all of them stable until mem_ack is seen high at a clock edge. On a read beat, mem_rdata is taken at that same edge.
- R11: req_ready is 1 only while the cache is idle. It stays 0 from the accepted request until completion. Completion is a single-cycle rsp_valid pulse. With that pulse, rsp_rdata carries the word for a load and zero for a store or prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Cache idle and able to take a request |
| req_op | input | 2 | Operation: 00 load, 01 store, 10 prefetch |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enable, bit i covers bits [8i+7:8i] |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, zero for other operations |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat word address |
| mem_wdata | output | 32 | Beat write data |
| mem_ack | input | 1 | Beat acknowledge, one cycle |
| mem_rdata | input | 32 | Beat read data, valid with mem_ack |

## Verification
A directed sequence drives three and then four tags into one set. This makes cold fills, clean and dirty evictions, a prefetched line that must leave without a write-back, and a store miss whose merged word later shows up in a write-back. Store byte enables of 0101, 1000, 1111 and 0000 separate correct merging from whole-word or no-op writes. The top tag in the last set checks the address split at its edge. A long random mix over four tags and three sets, with memory acknowledge delays of 0 to 2 cycles, catches victim-choice and recency errors, because a wrong way shows up as unexpected beat addresses or stale load data.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_PREF  = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOOK,
    S_EVICT,
    S_FILL
  } state_e;

  // byte lane merge: enabled lanes take the new word, others keep the old one
  function automatic logic [WORD_W-1:0] merge_bytes(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [BE_W-1:0]   be
  );
    logic [WORD_W-1:0] res;
    for (int b = 0; b < BE_W; b++) begin
      res[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int SETS  = 32,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic             hit_way,
  output logic             vic_way,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic             fill_en,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_en,
  input  logic             dirty_way
);
  localparam int WAYS = 2;

  logic [TAG_W-1:0] tag_q   [WAYS][SETS];
  logic [SETS-1:0]  val_q   [WAYS];
  logic [SETS-1:0]  dirty_q [WAYS];
  logic [SETS-1:0]  rec_q;
  logic [WAYS-1:0]  way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w] = val_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag);

    always_ff @(posedge clk) begin
      if (fill_en && (fill_way == 1'(w))) tag_q[w][lk_idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q[w]   <= '0;
        dirty_q[w] <= '0;
      end else begin
        if (fill_en && (fill_way == 1'(w))) begin
          val_q[w][lk_idx]   <= 1'b1;
          dirty_q[w][lk_idx] <= 1'b0;
        end else if (dirty_en && (dirty_way == 1'(w))) begin
          dirty_q[w][lk_idx] <= 1'b1;
        end
      end
    end
  end

  assign hit       = |way_hit;
  assign hit_way   = way_hit[1];
  assign vic_way   = rec_q[lk_idx];
  assign vic_dirty = val_q[vic_way][lk_idx] && dirty_q[vic_way][lk_idx];
  assign vic_tag   = tag_q[vic_way][lk_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) rec_q <= '0;
    else if (touch_en) rec_q[lk_idx] <= ~touch_way;
  end

  // R4: a line is never filled and touched in the same cycle
  a_r4_fill_not_touch: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !touch_en);
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 8,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int AW     = 1 + IDX_W + WSEL_W,
  localparam int DEPTH  = 2 * SETS * LINE_WORDS
) (
  input  logic                      clk,
  input  logic [IDX_W-1:0]          idx,
  input  logic                      rd_way,
  input  logic [WSEL_W-1:0]         rd_word,
  output logic [dc_pkg::WORD_W-1:0] rd_data,
  input  logic                      wr_en,
  input  logic                      wr_way,
  input  logic [WSEL_W-1:0]         wr_word,
  input  logic [dc_pkg::WORD_W-1:0] wr_data
);
  logic [dc_pkg::WORD_W-1:0] mem_q [DEPTH];

  function automatic logic [AW-1:0] slot(input logic way,
                                         input logic [IDX_W-1:0] i,
                                         input logic [WSEL_W-1:0] w);
    return {way, i, w};
  endfunction

  assign rd_data = mem_q[slot(rd_way, idx, rd_word)];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[slot(wr_way, idx, wr_word)] <= wr_data;
  end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 8,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int OFF_W  = WSEL_W + 2,
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              hit,
  input  logic              hit_way,
  input  logic              vic_way,
  input  logic              vic_dirty,
  input  logic [TAG_W-1:0]  vic_tag,
  output logic              touch_en,
  output logic              touch_way,
  output logic              fill_en,
  output logic              fill_way,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              dirty_en,
  output logic              dirty_way,
  output logic              rd_way,
  output logic [WSEL_W-1:0] rd_word,
  input  logic [WORD_W-1:0] rd_data,
  output logic              wr_en,
  output logic              wr_way,
  output logic [WSEL_W-1:0] wr_word,
  output logic [WORD_W-1:0] wr_data
);
  state_e            st;
  op_e               q_op;
  logic [ADDR_W-1:0] q_addr;
  logic [WORD_W-1:0] q_wdata;
  logic [BE_W-1:0]   q_be;
  logic              v_way;
  logic [TAG_W-1:0]  v_tag;
  logic [WSEL_W-1:0] cnt;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_rdata_q;

  logic [IDX_W-1:0]  q_idx;
  logic [TAG_W-1:0]  q_tag;
  logic [WSEL_W-1:0] q_word;

  // named internal events
  logic lk_hit_ev, lk_miss_ev, beat_ev, last_beat, wb_done, rf_done, store_hit_ev;

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i,
                                                  input logic [WSEL_W-1:0] w);
    return {t, i, w, 2'b00};
  endfunction

  assign q_idx  = q_addr[OFF_W +: IDX_W];
  assign q_tag  = q_addr[OFF_W + IDX_W +: TAG_W];
  assign q_word = q_addr[2 +: WSEL_W];

  assign lk_hit_ev    = (st == S_LOOK) && hit;
  assign lk_miss_ev   = (st == S_LOOK) && !hit;
  assign store_hit_ev = lk_hit_ev && (q_op == OP_STORE);
  assign beat_ev      = mem_req && mem_ack;
  assign last_beat    = (cnt == WSEL_W'(LINE_WORDS - 1));
  assign wb_done      = (st == S_EVICT) && beat_ev && last_beat;
  assign rf_done      = (st == S_FILL) && beat_ev && last_beat;

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  assign mem_req   = (st == S_EVICT) || (st == S_FILL);
  assign mem_we    = (st == S_EVICT);
  assign mem_addr  = (st == S_EVICT) ? beat_addr(v_tag, q_idx, cnt) : beat_addr(q_tag, q_idx, cnt);
  assign mem_wdata = (st == S_EVICT) ? rd_data : '0;

  assign lk_idx = q_idx;
  assign lk_tag = q_tag;

  assign rd_way  = (st == S_EVICT) ? v_way : hit_way;
  assign rd_word = (st == S_EVICT) ? cnt : q_word;

  assign touch_en  = lk_hit_ev;
  assign touch_way = hit_way;
  assign dirty_en  = store_hit_ev;
  assign dirty_way = hit_way;
  assign fill_en   = rf_done;
  assign fill_way  = v_way;
  assign fill_tag  = q_tag;

  assign wr_en   = store_hit_ev || ((st == S_FILL) && beat_ev);
  assign wr_way  = (st == S_FILL) ? v_way : hit_way;
  assign wr_word = (st == S_FILL) ? cnt : q_word;
  assign wr_data = (st == S_FILL) ? mem_rdata : merge_bytes(rd_data, q_wdata, q_be);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      q_op        <= OP_LOAD;
      q_addr      <= '0;
      q_wdata     <= '0;
      q_be        <= '0;
      v_way       <= 1'b0;
      v_tag       <= '0;
      cnt         <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (req_valid) begin
            q_op    <= op_e'(req_op);
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
            q_be    <= req_be;
            st      <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (lk_hit_ev) begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= (q_op == OP_LOAD) ? rd_data : '0;
            st          <= S_IDLE;
          end else begin
            v_way <= vic_way;
            v_tag <= vic_tag;
            cnt   <= '0;
            st    <= vic_dirty ? S_EVICT : S_FILL;
          end
        end
        S_EVICT: begin
          if (beat_ev) begin
            cnt <= cnt + 1'b1;
            if (wb_done) st <= S_FILL;
          end
        end
        S_FILL: begin
          if (beat_ev) begin
            cnt <= cnt + 1'b1;
            if (rf_done) st <= S_LOOK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r11_busy_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r5_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> (mem_req && !mem_we && (cnt == '0)));

  a_r2_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rf_done |=> lk_hit_ev);

  a_r6_miss_starts_beat: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss_ev |=> (mem_req && (cnt == '0)));
endmodule

// File: rtl/dcache_2way.sv
module dcache_2way #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int TAG_W  = ADDR_W - WSEL_W - 2 - IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag, vic_tag, fill_tag;
  logic              hit, hit_way, vic_way, vic_dirty;
  logic              touch_en, touch_way, fill_en, fill_way, dirty_en, dirty_way;
  logic              rd_way, wr_en, wr_way;
  logic [WSEL_W-1:0] rd_word, wr_word;
  logic [31:0]       rd_data, wr_data;

  dc_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .hit(hit), .hit_way(hit_way),
    .vic_way(vic_way), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .touch_en(touch_en), .touch_way(touch_way), .fill_en(fill_en), .fill_way(fill_way),
    .fill_tag(fill_tag), .dirty_en(dirty_en), .dirty_way(dirty_way),
    .rd_way(rd_way), .rd_word(rd_word), .rd_data(rd_data),
    .wr_en(wr_en), .wr_way(wr_way), .wr_word(wr_word), .wr_data(wr_data)
  );

  dc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_tag(lk_tag),
    .hit(hit), .hit_way(hit_way), .vic_way(vic_way), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .touch_en(touch_en), .touch_way(touch_way), .fill_en(fill_en), .fill_way(fill_way),
    .fill_tag(fill_tag), .dirty_en(dirty_en), .dirty_way(dirty_way)
  );

  dc_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk(clk), .idx(lk_idx), .rd_way(rd_way), .rd_word(rd_word), .rd_data(rd_data),
    .wr_en(wr_en), .wr_way(wr_way), .wr_word(wr_word), .wr_data(wr_data)
  );
endmodule

// File: tb/tb_dcache_2way.sv
`timescale 1ns/1ps
module tb_dcache_2way;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [1:0]  req_op;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  dcache_2way dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  logic [21:0] m_tag   [2][32];
  bit          m_val   [2][32];
  bit          m_dirty [2][32];
  logic [31:0] m_data  [2][32][8];
  bit          m_rec   [32];

  typedef struct { logic [31:0] a; bit we; logic [31:0] d; } xfer_t;
  xfer_t exp_q [$];

  logic [31:0] dev_mem [int unsigned];
  logic [31:0] mdl_mem [int unsigned];

  function automatic logic [31:0] seed_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A17_C3E9;
  endfunction

  function automatic logic [31:0] mdl_rd(input logic [31:0] a);
    return mdl_mem.exists(a) ? mdl_mem[a] : seed_word(a);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic predict(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, output logic [31:0] er);
    int s, w, hw, v;
    logic [21:0] tg;
    logic [31:0] base, ba, mask;
    s  = int'(a[9:5]);
    w  = int'(a[4:2]);
    tg = a[31:10];
    hw = -1;
    for (int k = 0; k < 2; k++) if (m_val[k][s] && m_tag[k][s] == tg) hw = k;
    if (hw < 0) begin
      v = m_rec[s] ? 1 : 0;
      if (m_val[v][s] && m_dirty[v][s]) begin
        base = (32'(m_tag[v][s]) << 10) | (32'(s) << 5);
        for (int i = 0; i < 8; i++) begin
          ba = base + 32'(4 * i);
          exp_q.push_back('{a: ba, we: 1'b1, d: m_data[v][s][i]});
          mdl_mem[ba] = m_data[v][s][i];
        end
      end
      base = (32'(tg) << 10) | (32'(s) << 5);
      for (int i = 0; i < 8; i++) begin
        ba = base + 32'(4 * i);
        exp_q.push_back('{a: ba, we: 1'b0, d: 32'h0});
        m_data[v][s][i] = mdl_rd(ba);
      end
      m_tag[v][s] = tg; m_val[v][s] = 1; m_dirty[v][s] = 0;
      hw = v;
    end
    m_rec[s] = (hw == 0);
    if (op == 2'b01) begin
      mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
      m_data[hw][s][w] = (d & mask) | (m_data[hw][s][w] & ~mask);
      m_dirty[hw][s] = 1;
    end
    er = (op == 2'b00) ? m_data[hw][s][w] : 32'h0;
  endtask

  // memory responder: checks each beat against the predicted stream
  initial begin : responder
    int lat;
    xfer_t x;
    mem_ack = 1'b0; mem_rdata = '0; lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (lat > 0) lat--;
        else begin
          if (exp_q.size() == 0) chk("R10 unexpected beat", mem_addr, 32'hxxxx_xxxx);
          else begin
            x = exp_q.pop_front();
            chk(x.we ? "R5 beat address" : "R6 beat address", mem_addr, x.a);
            chk("R10 beat direction", 32'(mem_we), 32'(x.we));
            if (x.we) chk("R5 beat data", mem_wdata, x.d);
          end
          if (mem_we) dev_mem[mem_addr] = mem_wdata;
          else mem_rdata = dev_mem.exists(mem_addr) ? dev_mem[mem_addr] : seed_word(mem_addr);
          mem_ack = 1'b1;
          lat = $urandom_range(0, 2);
        end
      end
    end
  end

  task automatic do_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] be, input string req);
    logic [31:0] er;
    int guard;
    bit done;
    predict(op, a, d, be, er);
    @(negedge clk);
    chk("R11 idle ready", 32'(req_ready), 32'd1);
    chk("R11 no stray pulse", 32'(rsp_valid), 32'd0);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    #1 req_valid = 1'b0;
    guard = 0; done = 0;
    while (!done) begin
      @(negedge clk);
      if (rsp_valid) begin
        chk(req, rsp_rdata, er);
        done = 1;
      end else begin
        chk("R11 busy", 32'(req_ready), 32'd0);
        guard++;
        if (guard > 2000) begin
          chk("R11 completion timeout", 32'd0, 32'd1);
          done = 1;
        end
      end
    end
    chk({req, " beat count"}, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  localparam logic [31:0] A = {22'd1, 5'd3, 5'd0};
  localparam logic [31:0] B = {22'd2, 5'd3, 5'd0};
  localparam logic [31:0] C = {22'd3, 5'd3, 5'd0};
  localparam logic [31:0] D = {22'd4, 5'd3, 5'd0};
  localparam logic [31:0] E = {22'd5, 5'd3, 5'd0};

  initial begin : main
    logic [21:0] tsel [4];
    logic [4:0]  ssel [3];
    for (int k = 0; k < 2; k++)
      for (int s = 0; s < 32; s++) begin m_val[k][s] = 0; m_dirty[k][s] = 0; m_tag[k][s] = '0; end
    for (int s = 0; s < 32; s++) m_rec[s] = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R11 reset ready", 32'(req_ready), 32'd1);
    chk("R11 reset pulse", 32'(rsp_valid), 32'd0);
    chk("R10 reset bus idle", 32'(mem_req), 32'd0);
    rst_n = 1'b1;

    do_op(2'b00, A + 32'd8,  '0, 4'h0, "R2 cold load miss");
    do_op(2'b00, A + 32'd20, '0, 4'h0, "R2 load hit");
    do_op(2'b01, A + 32'd8,  32'hAABB_CCDD, 4'b0101, "R7 store hit merge");
    do_op(2'b00, A + 32'd8,  '0, 4'h0, "R7 merged readback");
    do_op(2'b00, B + 32'd4,  '0, 4'h0, "R4 victim way 1");
    do_op(2'b00, C + 32'd0,  '0, 4'h0, "R5 dirty victim written back");
    do_op(2'b10, A + 32'd12, '0, 4'h0, "R9 prefetch miss");
    do_op(2'b00, C + 32'd28, '0, 4'h0, "R3 hit way 0 sets recency");
    do_op(2'b01, D + 32'd16, 32'h1122_3344, 4'b1000, "R8 store miss over clean prefetched line");
    do_op(2'b10, D + 32'd16, '0, 4'h0, "R9 prefetch hit");
    do_op(2'b00, E + 32'd0,  '0, 4'h0, "R4 clean victim no writeback");
    do_op(2'b00, A + 32'd0,  '0, 4'h0, "R8 merged word evicted");
    do_op(2'b01, 32'h0000_0044, 32'hDEAD_BEEF, 4'b1111, "R7 full word store");
    do_op(2'b01, 32'h0000_0044, 32'h0BAD_F00D, 4'b0000, "R7 empty mask store");
    do_op(2'b00, 32'h0000_0047, '0, 4'h0, "R1 low bits ignored");
    do_op(2'b00, 32'hFFFF_FFFC, '0, 4'h0, "R1 top tag last set");
    do_op(2'b01, 32'hFFFF_FFE0, 32'h0F0F_0F0F, 4'b0011, "R1 top tag store");

    tsel = '{22'd0, 22'd1, 22'h3F_FFFF, 22'h155};
    ssel = '{5'd0, 5'd1, 5'd31};
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra;
      logic [1:0]  rop;
      ra  = {tsel[$urandom_range(0, 3)], ssel[$urandom_range(0, 2)], 3'($urandom_range(0, 7)), 2'b00};
      rop = 2'($urandom_range(0, 2));
      do_op(rop, ra, $urandom(), 4'($urandom_range(0, 15)),
            rop == 2'b00 ? "R3 random load" : (rop == 2'b01 ? "R7 random store" : "R9 random prefetch"));
    end
    for (int s = 0; s < 3; s++)
      for (int t = 0; t < 4; t++)
        do_op(2'b00, {tsel[t], ssel[s], 5'd0}, '0, 4'h0, "R6 sweep load");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule